// File: doc/BRIEF.md
# Display Frame Bus-Request Timer

This block is a free-running cycle counter clocked at the processor rate. It sets the frame timing of a tile-based video controller. Each frame is a fixed number of processor cycles. During the frame the block pulses a mode-switch strobe once, at the point where the shared display bus moves from processor control to video control. It then drives an active-low bus request low once for each of twelve rows of tiles, so that the video side can fetch that row. On the cycle the frame wraps, it raises a one-cycle frame interrupt.

The request windows move with a vertical-delay value. Each window starts at a base cycle, plus a fixed step per delay unit, plus a larger step per row. Every window has the same length. When the vertical delay is zero, a further dummy request runs from late in the frame up to the wrap. A display-enable input can turn off all requests. Turning the display off does not change the frame length, the mode-switch strobe or the interrupt. Both inputs are sampled once per frame, so changes in the middle of a frame do not disturb the current schedule.

Top module: `frame_bus_timer`

## Requirements
- R1: While reset is held, busReqN is 1, frameIrq is 0 and modeSwitch is 0. The cycle in which reset is released is frame cycle 0.
- R2: A frame lasts 14934 cycles. frameIrq is 1 for exactly one cycle, on frame cycle 0 of every frame after the first, which is 14934 cycles after the previous frame start.
- R3: modeSwitch is 1 for exactly one cycle per frame, on frame cycle 3790.
- R4: With the display enabled and sampled delay v (0 to 7), busReqN is 0 on every frame cycle t with 3933+114v+912r <= t < 4043+114v+912r, for rows r = 0 to 11.
- R5: Only when the sampled delay is 0 (and the display is enabled), busReqN is also 0 for frame cycles 14877 to 14933, and it returns to 1 on frame cycle 0.
- R6: With the display disabled, busReqN stays 1 for the whole frame, while frameIrq and modeSwitch keep the timing of R2 and R3.
- R7: vDelay and dispEnable are sampled at the clock edge that ends frame cycle 0. Changes to them later in the frame have no effect until the next frame.
- R8: busReqN is 1 on every frame cycle that is not covered by R4 or R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor-rate clock |
| rstN | input | 1 | Asynchronous active-low reset |
| vDelay | input | 3 | Vertical delay, sampled once per frame |
| dispEnable | input | 1 | Display enable, sampled once per frame |
| busReqN | output | 1 | Active-low, registered row-fetch bus request |
| modeSwitch | output | 1 | One-cycle pulse at the processor-to-video handover |
| frameIrq | output | 1 | One-cycle frame interrupt pulse at frame wrap |

## Verification
The assertions check, on every cycle, the invariants that hold in any frame:
- the interrupt and the mode strobe each last one cycle and sit at their fixed distances from the frame start;
- the two strobes never coincide;
- no request appears before the first row window or while the latched enable is off;
- the request is released on the wrap cycle.

Only the bench scenarios can show the exact placement of every window edge for each delay value. They also show that the dummy fetch appears only at delay zero and that a change of delay in mid-frame is held off until the next frame. The bench does this by comparing every cycle of whole frames against a schedule it computes itself.

// File: rtl/frame_timer_pkg.sv
package frame_timer_pkg;
  // Strobes passed from the control counter to the output datapath
  typedef struct packed {
    logic sample;    // current cycle is frame cycle 0: latch frame inputs
    logic wrapNext;  // next cycle is frame cycle 0
    logic modeNext;  // next cycle is the handover cycle
  } strobe_t;
endpackage

// File: rtl/frame_ctrl.sv
module frame_ctrl
  import frame_timer_pkg::*;
#(
  parameter int unsigned FRAME_LEN = 14934,
  parameter int unsigned MODE_AT   = 3790,
  parameter int unsigned CNT_W     = $clog2(FRAME_LEN)
) (
  input  logic             clk,
  input  logic             rstN,
  output logic [CNT_W-1:0] nextCnt,
  output strobe_t          strobes
);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(FRAME_LEN - 1);
  localparam logic [CNT_W-1:0] MODE_CNT = CNT_W'(MODE_AT);

  logic [CNT_W-1:0] cnt;

  always_comb begin
    nextCnt = (cnt == LAST_CNT) ? '0 : cnt + 1'b1;
    strobes.sample   = (cnt == '0);
    strobes.wrapNext = (nextCnt == '0);
    strobes.modeNext = (nextCnt == MODE_CNT);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cnt <= '0;
    else       cnt <= nextCnt;
  end
endmodule

// File: rtl/frame_datapath.sv
module frame_datapath
  import frame_timer_pkg::*;
#(
  parameter int unsigned CNT_W       = 14,
  parameter int unsigned VD_W        = 3,
  parameter int unsigned ROWS        = 12,
  parameter int unsigned REQ_BASE    = 3933,
  parameter int unsigned REQ_LEN     = 110,
  parameter int unsigned VD_STEP     = 114,
  parameter int unsigned ROW_STEP    = 912,
  parameter int unsigned EXTRA_START = 14877
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] nextCnt,
  input  strobe_t          strobes,
  input  logic [VD_W-1:0]  vDelay,
  input  logic             dispEnable,
  output logic             dispLatched,
  output logic             busReqN,
  output logic             modeSwitch,
  output logic             frameIrq
);
  logic [VD_W-1:0] vdLat;
  logic [31:0]     cntWide;
  logic [31:0]     vdOffset;
  logic [ROWS-1:0] rowHit;
  logic            extraHit;
  logic            reqNext;

  always_comb begin
    cntWide  = 32'(nextCnt);
    vdOffset = VD_STEP * 32'(vdLat);
  end

  // One window comparator per tile row
  for (genvar r = 0; r < ROWS; r++) begin : g_row
    logic [31:0] winStart;
    always_comb begin
      winStart  = REQ_BASE + vdOffset + ROW_STEP * r;
      rowHit[r] = (cntWide >= winStart) && (cntWide < winStart + REQ_LEN);
    end
  end

  always_comb begin
    extraHit = (vdLat == '0) && (cntWide >= EXTRA_START);
    reqNext  = dispLatched && ((|rowHit) || extraHit);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vdLat       <= '0;
      dispLatched <= 1'b0;
      busReqN     <= 1'b1;
      modeSwitch  <= 1'b0;
      frameIrq    <= 1'b0;
    end else begin
      if (strobes.sample) begin
        vdLat       <= vDelay;
        dispLatched <= dispEnable;
      end
      busReqN    <= ~reqNext;
      modeSwitch <= strobes.modeNext;
      frameIrq   <= strobes.wrapNext;
    end
  end
endmodule

// File: rtl/frame_bus_timer.sv
module frame_bus_timer
  import frame_timer_pkg::*;
#(
  parameter int unsigned FRAME_LEN   = 14934,
  parameter int unsigned MODE_AT     = 3790,
  parameter int unsigned VD_W        = 3,
  parameter int unsigned ROWS        = 12,
  parameter int unsigned REQ_BASE    = 3933,
  parameter int unsigned REQ_LEN     = 110,
  parameter int unsigned VD_STEP     = 114,
  parameter int unsigned ROW_STEP    = 912,
  parameter int unsigned EXTRA_START = 14877
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [VD_W-1:0] vDelay,
  input  logic            dispEnable,
  output logic            busReqN,
  output logic            modeSwitch,
  output logic            frameIrq
);
  localparam int unsigned CNT_W = $clog2(FRAME_LEN);

  logic [CNT_W-1:0] nextCnt;
  strobe_t          strobes;
  logic             dispLatched;

  frame_ctrl #(
    .FRAME_LEN(FRAME_LEN), .MODE_AT(MODE_AT), .CNT_W(CNT_W)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .nextCnt(nextCnt), .strobes(strobes)
  );

  frame_datapath #(
    .CNT_W(CNT_W), .VD_W(VD_W), .ROWS(ROWS), .REQ_BASE(REQ_BASE),
    .REQ_LEN(REQ_LEN), .VD_STEP(VD_STEP), .ROW_STEP(ROW_STEP),
    .EXTRA_START(EXTRA_START)
  ) dp_i (
    .clk(clk), .rstN(rstN), .nextCnt(nextCnt), .strobes(strobes),
    .vDelay(vDelay), .dispEnable(dispEnable), .dispLatched(dispLatched),
    .busReqN(busReqN), .modeSwitch(modeSwitch), .frameIrq(frameIrq)
  );
endmodule

// File: rtl/frame_bus_timer_chk.sv
module frame_bus_timer_chk #(
  parameter int unsigned FRAME_LEN = 14934,
  parameter int unsigned MODE_AT   = 3790,
  parameter int unsigned REQ_BASE  = 3933
) (
  input logic clk,
  input logic rstN,
  input logic busReqN,
  input logic modeSwitch,
  input logic frameIrq,
  input logic dispLatched
);
  // Cycles elapsed since the last interrupt (or since reset)
  logic [31:0] sinceIrq;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         sinceIrq <= 32'd0;
    else if (frameIrq) sinceIrq <= 32'd1;
    else               sinceIrq <= sinceIrq + 32'd1;
  end

  AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    frameIrq |=> !frameIrq);  // R2
  AST_IRQ_PERIOD: assert property (@(posedge clk) disable iff (!rstN)
    frameIrq |-> (sinceIrq == FRAME_LEN));  // R2
  AST_MODE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    modeSwitch |=> !modeSwitch);  // R3
  AST_MODE_POSITION: assert property (@(posedge clk) disable iff (!rstN)
    modeSwitch |-> (sinceIrq == MODE_AT));  // R3
  AST_STROBES_APART: assert property (@(posedge clk) disable iff (!rstN)
    !(modeSwitch && frameIrq));  // R3
  AST_NO_EARLY_REQ: assert property (@(posedge clk) disable iff (!rstN)
    !busReqN |-> (sinceIrq >= REQ_BASE));  // R8
  AST_REQ_FREE_AT_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    frameIrq |-> busReqN);  // R5
  AST_NO_REQ_DISABLED: assert property (@(posedge clk) disable iff (!rstN)
    !dispLatched |-> busReqN);  // R6
endmodule

bind frame_bus_timer frame_bus_timer_chk #(
  .FRAME_LEN(FRAME_LEN), .MODE_AT(MODE_AT), .REQ_BASE(REQ_BASE)
) chk_i (
  .clk(clk), .rstN(rstN), .busReqN(busReqN), .modeSwitch(modeSwitch),
  .frameIrq(frameIrq), .dispLatched(dispLatched)
);

// File: tb/frame_bus_timer_tb_top.sv
module frame_bus_timer_tb_top;
  localparam int FRAME = 14934;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] vDelay = 3'd0;
  logic       dispEnable = 1'b0;
  logic       busReqN, modeSwitch, frameIrq;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  frame_bus_timer dut_i (
    .clk(clk), .rstN(rstN), .vDelay(vDelay), .dispEnable(dispEnable),
    .busReqN(busReqN), .modeSwitch(modeSwitch), .frameIrq(frameIrq)
  );

  function automatic logic expReqN(int t, int v, bit en);
    if (!en) return 1'b1;
    for (int r = 0; r < 12; r++) begin
      int s = 3933 + 114 * v + 912 * r;
      if (t >= s && t < s + 110) return 1'b0;
    end
    if (v == 0 && t >= 14877) return 1'b0;
    return 1'b1;
  endfunction

  task automatic check1(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Runs one whole frame starting at frame cycle 0 (current negedge).
  // Ends on frame cycle 0 of the following frame.
  task automatic runFrame(int v, bit en, int midV, bit first, string reqTag);
    int eR = 0, eI = 0, eM = 0;
    vDelay = 3'(v);
    dispEnable = en;
    for (int t = 0; t < FRAME; t++) begin
      logic xr, xi, xm;
      if (t > 0) @(negedge clk);
      if (t == 100) begin
        vDelay = 3'(midV);       // R7: mid-frame changes must be ignored
        dispEnable = ~en;
      end
      xr = expReqN(t, v, en);
      xi = (t == 0) && !first;
      xm = (t == 3790);
      if (busReqN !== xr) begin
        if (eR == 0)
          $display("FAIL %s busReqN v=%0d t=%0d actual=%0b expected=%0b",
                   reqTag, v, t, busReqN, xr);
        eR++;
      end
      if (frameIrq !== xi) begin
        if (eI == 0)
          $display("FAIL R2 frameIrq v=%0d t=%0d actual=%0b expected=%0b",
                   v, t, frameIrq, xi);
        eI++;
      end
      if (modeSwitch !== xm) begin
        if (eM == 0)
          $display("FAIL R3 modeSwitch v=%0d t=%0d actual=%0b expected=%0b",
                   v, t, modeSwitch, xm);
        eM++;
      end
    end
    checks += 3;
    errors += (eR != 0) + (eI != 0) + (eM != 0);
    vDelay = 3'(v);
    dispEnable = en;
    @(negedge clk);
  endtask

  task automatic testReset();
    repeat (3) @(negedge clk);
    check1("R1", "busReqN in reset", int'(busReqN), 1);
    check1("R1", "frameIrq in reset", int'(frameIrq), 0);
    check1("R1", "modeSwitch in reset", int'(modeSwitch), 0);
    rstN = 1'b1;               // this negedge is frame cycle 0
  endtask

  task automatic testAllDelays();
    for (int v = 0; v < 8; v++)
      runFrame(v, 1'b1, v, v == 0, (v == 0) ? "R4/R5" : "R4 R8");
  endtask

  task automatic testDisabled();
    runFrame(0, 1'b0, 0, 1'b0, "R6");
  endtask

  task automatic testMidChange();
    runFrame(5, 1'b1, 0, 1'b0, "R7");
    runFrame(0, 1'b1, 6, 1'b0, "R7 R5");
  endtask

  initial begin
    testReset();
    testAllDelays();
    testDisabled();
    testMidChange();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule